// File: doc/BRIEF.md
# Per-Thread Fetch Status Controller

This block keeps the fetch status of every hardware thread in a multithreaded fetch stage and updates it once per clock. Each cycle it takes stall requests from four downstream pipeline stages, redirect requests from commit and decode, a flag saying the reorder buffer is still flushing, and events from the instruction-cache path and the fetch selector. From these it settles on one status per thread and a redirect PC per thread.

Every thread holds four sticky stall flags, one for each downstream stage. A stage raises a block pulse to set its flag and an unblock pulse to clear it. A chip-wide context-switch input counts as a stall for all threads. Redirects are applied in a fixed priority. A thread that is waiting on the instruction cache, or that is parked after a fault or a quiesce, is not pushed into the blocked state by a stall. A stage-level activity output tells the pipeline whether any enabled thread can make progress.

Top module: `fetch_status_ctrl`

## Requirements
- R1: Reset is synchronous and active-low. After reset every thread status is RUN, every redirect PC is 0 and every stall flag is clear. Status codes are 3 bits: RUN=0, SQUASH=1, BLOCK=2, WAIT_RESP=3, WAIT_RETRY=4, LINE_READY=5, TRAP=6, QUIESCE=7.
- R2: Each thread has one sticky stall flag for each of decode, rename, execute and commit. A block pulse sets the flag and an unblock pulse clears it. A stall is present when any updated flag is set or `ctx_switch` is high. Unblock never arrives together with block, and arrives only while the flag is set.
- R3: A commit squash has the highest priority. The thread goes to SQUASH and loads its PC from `cmt_redirect_pc`.
- R4: Otherwise, `rob_squashing` puts the thread in SQUASH and leaves its PC unchanged.
- R5: Otherwise, a decode squash loads `dec_redirect_pc` and enters SQUASH, but only when the thread is not already in SQUASH. In SQUASH the decode squash is ignored and the PC stays as it was.
- R6: Otherwise, a stall moves the thread to BLOCK unless the thread is in WAIT_RESP, WAIT_RETRY, TRAP or QUIESCE.
- R7: Otherwise, a thread in BLOCK or SQUASH returns to RUN. When no rule fires, the status does not change.
- R8: Cache path, applied only when R3 to R7 do not fire. From RUN, a miss gives WAIT_RESP, and a refused request gives WAIT_RETRY if there was no miss. From WAIT_RETRY, a retry grant gives WAIT_RESP. From WAIT_RESP, a response gives BLOCK if a stall is present and LINE_READY if not. From LINE_READY, being selected for fetch gives RUN.
- R9: From RUN, a fetch fault gives TRAP and a quiesce gives QUIESCE, in that priority and ahead of the cache events. TRAP and QUIESCE are left only through a squash (R3 to R5), or through `wake`, which returns the thread to RUN.
- R10: A thread whose `thread_active` bit is low keeps its status, PC and stall flags, whatever its other inputs are.
- R11: `stage_active` is high exactly when some thread with `thread_active` set is in RUN, SQUASH or LINE_READY.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| thread_active | input | NT | Threads that are evaluated this cycle |
| ctx_switch | input | 1 | Context switch, acts as a stall for all threads |
| dec_block | input | NT | Decode stall set pulse, one per thread |
| dec_unblock | input | NT | Decode stall clear pulse |
| ren_block | input | NT | Rename stall set pulse |
| ren_unblock | input | NT | Rename stall clear pulse |
| exe_block | input | NT | Execute stall set pulse |
| exe_unblock | input | NT | Execute stall clear pulse |
| cmt_block | input | NT | Commit stall set pulse |
| cmt_unblock | input | NT | Commit stall clear pulse |
| cmt_squash | input | NT | Commit redirect request |
| cmt_redirect_pc | input | NT*PC_W | Commit redirect PC per thread |
| rob_squashing | input | NT | Reorder buffer still flushing |
| dec_squash | input | NT | Decode redirect request |
| dec_redirect_pc | input | NT*PC_W | Decode redirect PC per thread |
| icache_miss | input | NT | Line request sent, response pending |
| icache_refused | input | NT | Line request refused, retry needed |
| icache_retry_ok | input | NT | Refused request was accepted on retry |
| icache_resp | input | NT | Line response arrived |
| fetch_select | input | NT | Thread chosen by the fetch selector |
| fetch_fault | input | NT | Fault detected at fetch |
| quiesce_hit | input | NT | Quiesce instruction fetched |
| wake | input | NT | Release from TRAP or QUIESCE |
| thread_status | output | NT*3 | Status code per thread (codes in R1) |
| thread_pc | output | NT*PC_W | Redirect PC per thread |
| stage_active | output | 1 | Some enabled thread can make progress |

## Verification
Random stimulus drives all redirect, stall and cache inputs at once, at rates that often stack commit squash, flush and decode squash in the same cycle. This separates the priority order of R3 to R5 from any other order. Unblock pulses are generated only for flags that are set, so flags build up and clear over many cycles, and a stall that arrives while a thread waits on the cache, or sits in TRAP, shows whether the exemption in R6 holds. Directed cycles cover a response that lands under a stall, a decode squash that arrives while the thread is already in SQUASH, a wake from TRAP while a stall is pending, and a disabled thread that receives a commit squash.

// File: rtl/fsc_pkg.sv
// Package: shared status encoding and stage count for the fetch status controller.
package fsc_pkg;
    localparam int NUM_STAGES = 4;   // decode, rename, execute, commit
    localparam int ST_W       = 3;

    typedef enum logic [ST_W-1:0] {
        TS_RUN        = 3'd0,
        TS_SQUASH     = 3'd1,
        TS_BLOCK      = 3'd2,
        TS_WAIT_RESP  = 3'd3,
        TS_WAIT_RETRY = 3'd4,
        TS_LINE_READY = 3'd5,
        TS_TRAP       = 3'd6,
        TS_QUIESCE    = 3'd7
    } thr_state_e;
endpackage

// File: rtl/fsc_stall_flags.sv
// Module: fsc_stall_flags
// Holds the sticky stall flags of one thread, one flag per downstream stage.
// Produces the stall for this cycle from the updated flags and the context switch.
// Assumes that unblock comes only while its flag is set, and never together with block.
module fsc_stall_flags #(
    parameter int NS = fsc_pkg::NUM_STAGES
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [NS-1:0] blk,
    input  logic [NS-1:0] unblk,
    input  logic          ctx_switch,
    output logic          stall_now
);
    logic [NS-1:0] flags_q;
    logic [NS-1:0] flags_d;

    generate
        for (genvar s = 0; s < NS; s++) begin : g_stage
            // Next value of one flag: set wins, then clear, else hold.
            always_comb begin
                if (blk[s])        flags_d[s] = 1'b1;
                else if (unblk[s]) flags_d[s] = 1'b0;
                else               flags_d[s] = flags_q[s];
            end

            // Register the flag while the thread is enabled.
            always_ff @(posedge clk) begin
                if (!rst_n)  flags_q[s] <= 1'b0;
                else if (en) flags_q[s] <= flags_d[s];
            end

            assert_unblock_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
                en && unblk[s] |-> flags_q[s] && !blk[s]);
            assert_block_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
                en && blk[s] |=> flags_q[s]);
        end
    endgenerate

    // A stall exists when any updated flag is set or a context switch is under way.
    always_comb stall_now = ctx_switch | (|flags_d);
endmodule

// File: rtl/fsc_thread_fsm.sv
// Module: fsc_thread_fsm
// Status state machine and redirect PC of one thread.
// The order is fixed: commit squash, flush, decode squash, stall, recovery, then local events.
// Assumes that the stall input already includes this cycle's flag updates.
module fsc_thread_fsm #(
    parameter int PC_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en,
    input  logic                stall,
    input  logic                csq,
    input  logic [PC_W-1:0]     cpc,
    input  logic                rob,
    input  logic                dsq,
    input  logic [PC_W-1:0]     dpc,
    input  logic                miss,
    input  logic                refused,
    input  logic                retry_ok,
    input  logic                resp,
    input  logic                sel,
    input  logic                fault,
    input  logic                quiesce,
    input  logic                wake,
    output fsc_pkg::thr_state_e state_q,
    output logic [PC_W-1:0]     pc_q
);
    import fsc_pkg::*;

    thr_state_e      st_d;
    logic [PC_W-1:0] pc_d;
    logic            exempt;

    // States that a stall may not move to BLOCK.
    always_comb exempt = (state_q == TS_WAIT_RESP) || (state_q == TS_WAIT_RETRY) ||
                         (state_q == TS_TRAP)      || (state_q == TS_QUIESCE);

    // Next status and PC in fixed priority.
    always_comb begin
        st_d = state_q;
        pc_d = pc_q;
        if (csq) begin
            st_d = TS_SQUASH;
            pc_d = cpc;
        end else if (rob) begin
            st_d = TS_SQUASH;
        end else if (dsq && state_q != TS_SQUASH) begin
            st_d = TS_SQUASH;
            pc_d = dpc;
        end else if (stall && !exempt) begin
            st_d = TS_BLOCK;
        end else if (state_q == TS_BLOCK || state_q == TS_SQUASH) begin
            st_d = TS_RUN;
        end else begin
            case (state_q)
                TS_RUN: begin
                    if (fault)        st_d = TS_TRAP;
                    else if (quiesce) st_d = TS_QUIESCE;
                    else if (miss)    st_d = TS_WAIT_RESP;
                    else if (refused) st_d = TS_WAIT_RETRY;
                end
                TS_WAIT_RETRY: if (retry_ok) st_d = TS_WAIT_RESP;
                TS_WAIT_RESP:  if (resp) st_d = stall ? TS_BLOCK : TS_LINE_READY;
                TS_LINE_READY: if (sel) st_d = TS_RUN;
                TS_TRAP, TS_QUIESCE: if (wake) st_d = TS_RUN;
                default: st_d = state_q;
            endcase
        end
    end

    // Status and PC registers, updated only for an enabled thread.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TS_RUN;
            pc_q    <= '0;
        end else if (en) begin
            state_q <= st_d;
            pc_q    <= pc_d;
        end
    end

    assert_commit_squash_R3: assert property (@(posedge clk) disable iff (!rst_n)
        en && csq |=> state_q == TS_SQUASH && pc_q == $past(cpc));
    assert_flush_holds_pc_R4: assert property (@(posedge clk) disable iff (!rst_n)
        en && !csq && rob |=> state_q == TS_SQUASH && $stable(pc_q));
    assert_decode_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
        en && !csq && !rob && state_q == TS_SQUASH |=> $stable(pc_q));
    assert_wait_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
        en && state_q == TS_WAIT_RESP && !csq && !rob && !dsq && !resp |=> state_q == TS_WAIT_RESP);
    assert_trap_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        en && state_q == TS_TRAP && !csq && !rob && !dsq && !wake |=> state_q == TS_TRAP);
    assert_inactive_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(state_q) && $stable(pc_q));
endmodule

// File: rtl/fsc_activity.sv
// Module: fsc_activity
// Reduces the thread statuses to one stage-active flag.
// Assumes that the status vector holds NT packed 3-bit codes, thread 0 in the low bits.
module fsc_activity #(
    parameter int NT = 4
) (
    input  logic [NT*fsc_pkg::ST_W-1:0] status,
    input  logic [NT-1:0]               active,
    output logic                        stage_active
);
    import fsc_pkg::*;

    logic [NT-1:0] can_go;

    generate
        for (genvar t = 0; t < NT; t++) begin : g_thr
            // A thread makes progress if it is enabled and in a state that can move.
            always_comb can_go[t] = active[t] &&
                ((status[t*ST_W +: ST_W] == TS_RUN)    ||
                 (status[t*ST_W +: ST_W] == TS_SQUASH) ||
                 (status[t*ST_W +: ST_W] == TS_LINE_READY));
        end
    endgenerate

    // The stage is active when any thread can make progress.
    always_comb stage_active = |can_go;
endmodule

// File: rtl/fetch_status_ctrl.sv
// Module: fetch_status_ctrl (top)
// Keeps the per-thread fetch status and redirect PC, and the stage activity flag.
// Builds one stall-flag set and one state machine for each thread.
// Assumes that all inputs are synchronous to clk and that the stall protocol of R2 holds.
module fetch_status_ctrl #(
    parameter int NT   = 4,
    parameter int PC_W = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NT-1:0]                thread_active,
    input  logic                         ctx_switch,
    input  logic [NT-1:0]                dec_block,
    input  logic [NT-1:0]                dec_unblock,
    input  logic [NT-1:0]                ren_block,
    input  logic [NT-1:0]                ren_unblock,
    input  logic [NT-1:0]                exe_block,
    input  logic [NT-1:0]                exe_unblock,
    input  logic [NT-1:0]                cmt_block,
    input  logic [NT-1:0]                cmt_unblock,
    input  logic [NT-1:0]                cmt_squash,
    input  logic [NT*PC_W-1:0]           cmt_redirect_pc,
    input  logic [NT-1:0]                rob_squashing,
    input  logic [NT-1:0]                dec_squash,
    input  logic [NT*PC_W-1:0]           dec_redirect_pc,
    input  logic [NT-1:0]                icache_miss,
    input  logic [NT-1:0]                icache_refused,
    input  logic [NT-1:0]                icache_retry_ok,
    input  logic [NT-1:0]                icache_resp,
    input  logic [NT-1:0]                fetch_select,
    input  logic [NT-1:0]                fetch_fault,
    input  logic [NT-1:0]                quiesce_hit,
    input  logic [NT-1:0]                wake,
    output logic [NT*fsc_pkg::ST_W-1:0]  thread_status,
    output logic [NT*PC_W-1:0]           thread_pc,
    output logic                         stage_active
);
    import fsc_pkg::*;

    logic [NT-1:0] stall_now;

    generate
        for (genvar t = 0; t < NT; t++) begin : g_thread
            logic [NUM_STAGES-1:0] blk;
            logic [NUM_STAGES-1:0] unblk;
            thr_state_e            st;

            // Gather this thread's stall pulses; bit 0 is decode, bit 3 is commit.
            always_comb begin
                blk   = {cmt_block[t],   exe_block[t],   ren_block[t],   dec_block[t]};
                unblk = {cmt_unblock[t], exe_unblock[t], ren_unblock[t], dec_unblock[t]};
            end

            fsc_stall_flags #(.NS(NUM_STAGES)) u_flags (
                .clk        (clk),
                .rst_n      (rst_n),
                .en         (thread_active[t]),
                .blk        (blk),
                .unblk      (unblk),
                .ctx_switch (ctx_switch),
                .stall_now  (stall_now[t])
            );

            fsc_thread_fsm #(.PC_W(PC_W)) u_fsm (
                .clk      (clk),
                .rst_n    (rst_n),
                .en       (thread_active[t]),
                .stall    (stall_now[t]),
                .csq      (cmt_squash[t]),
                .cpc      (cmt_redirect_pc[t*PC_W +: PC_W]),
                .rob      (rob_squashing[t]),
                .dsq      (dec_squash[t]),
                .dpc      (dec_redirect_pc[t*PC_W +: PC_W]),
                .miss     (icache_miss[t]),
                .refused  (icache_refused[t]),
                .retry_ok (icache_retry_ok[t]),
                .resp     (icache_resp[t]),
                .sel      (fetch_select[t]),
                .fault    (fetch_fault[t]),
                .quiesce  (quiesce_hit[t]),
                .wake     (wake[t]),
                .state_q  (st),
                .pc_q     (thread_pc[t*PC_W +: PC_W])
            );

            // Pack the status code onto the output bus.
            always_comb thread_status[t*ST_W +: ST_W] = st;
        end
    endgenerate

    fsc_activity #(.NT(NT)) u_act (
        .status       (thread_status),
        .active       (thread_active),
        .stage_active (stage_active)
    );
endmodule

// File: tb/fetch_status_ctrl_tb_top.sv
`timescale 1ns/1ps
module fetch_status_ctrl_tb_top;
    localparam int NT   = 4;
    localparam int PC_W = 32;
    localparam int NRND = 3000;

    localparam logic [2:0] S_RUN = 3'd0, S_SQ = 3'd1, S_BLK = 3'd2, S_WRESP = 3'd3,
                           S_WRETRY = 3'd4, S_READY = 3'd5, S_TRAP = 3'd6, S_QUI = 3'd7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic [NT-1:0] thread_active, dec_block, dec_unblock, ren_block, ren_unblock;
    logic [NT-1:0] exe_block, exe_unblock, cmt_block, cmt_unblock, cmt_squash, rob_squashing;
    logic [NT-1:0] dec_squash, icache_miss, icache_refused, icache_retry_ok, icache_resp;
    logic [NT-1:0] fetch_select, fetch_fault, quiesce_hit, wake;
    logic          ctx_switch;
    logic [NT*PC_W-1:0] cmt_redirect_pc, dec_redirect_pc, thread_pc;
    logic [NT*3-1:0]    thread_status;
    logic               stage_active;

    fetch_status_ctrl #(.NT(NT), .PC_W(PC_W)) dut_i (.*);

    // Reference model state
    logic [2:0]      m_st   [NT];
    logic [PC_W-1:0] m_pc   [NT];
    logic [3:0]      m_flag [NT];
    string           m_tag  [NT];
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic clear_in();
        {dec_block, dec_unblock, ren_block, ren_unblock, exe_block, exe_unblock} = '0;
        {cmt_block, cmt_unblock, cmt_squash, rob_squashing, dec_squash} = '0;
        {icache_miss, icache_refused, icache_retry_ok, icache_resp} = '0;
        {fetch_select, fetch_fault, quiesce_hit, wake} = '0;
        ctx_switch = 1'b0;
        thread_active = '1;
        cmt_redirect_pc = '0;
        dec_redirect_pc = '0;
    endtask

    function automatic bit exp_active();
        bit a = 1'b0;
        for (int t = 0; t < NT; t++)
            if (thread_active[t] && (m_st[t] == S_RUN || m_st[t] == S_SQ || m_st[t] == S_READY))
                a = 1'b1;
        return a;
    endfunction

    // Advance the model by one clock using the inputs now applied.
    task automatic model_step();
        for (int t = 0; t < NT; t++) begin
            logic [3:0] blk, unb, nf;
            logic [2:0] c;
            bit stall, ex;
            if (!thread_active[t]) begin
                m_tag[t] = "R10";
                continue;
            end
            blk = {cmt_block[t], exe_block[t], ren_block[t], dec_block[t]};
            unb = {cmt_unblock[t], exe_unblock[t], ren_unblock[t], dec_unblock[t]};
            nf = (m_flag[t] | blk) & ~(unb & ~blk);
            m_flag[t] = nf;
            stall = ctx_switch || (nf != 0);
            c = m_st[t];
            ex = (c == S_WRESP || c == S_WRETRY || c == S_TRAP || c == S_QUI);
            if (cmt_squash[t]) begin
                m_st[t] = S_SQ; m_pc[t] = cmt_redirect_pc[t*PC_W +: PC_W]; m_tag[t] = "R3";
            end else if (rob_squashing[t]) begin
                m_st[t] = S_SQ; m_tag[t] = "R4";
            end else if (dec_squash[t] && c != S_SQ) begin
                m_st[t] = S_SQ; m_pc[t] = dec_redirect_pc[t*PC_W +: PC_W]; m_tag[t] = "R5";
            end else if (stall && !ex) begin
                m_st[t] = S_BLK; m_tag[t] = ctx_switch ? "R6" : "R2";
            end else if (c == S_BLK || c == S_SQ) begin
                m_st[t] = S_RUN; m_tag[t] = dec_squash[t] ? "R5" : "R7";
            end else begin
                m_tag[t] = "R8";
                case (c)
                    S_RUN: begin
                        if (fetch_fault[t])         begin m_st[t] = S_TRAP; m_tag[t] = "R9"; end
                        else if (quiesce_hit[t])    begin m_st[t] = S_QUI;  m_tag[t] = "R9"; end
                        else if (icache_miss[t])    m_st[t] = S_WRESP;
                        else if (icache_refused[t]) m_st[t] = S_WRETRY;
                        else m_tag[t] = "R7";
                    end
                    S_WRETRY: if (icache_retry_ok[t]) m_st[t] = S_WRESP;
                    S_WRESP: begin
                        if (icache_resp[t]) m_st[t] = stall ? S_BLK : S_READY;
                        else if (stall) m_tag[t] = "R6";
                    end
                    S_READY: if (fetch_select[t]) m_st[t] = S_RUN;
                    default: begin
                        m_tag[t] = "R9";
                        if (wake[t]) m_st[t] = S_RUN;
                    end
                endcase
            end
        end
    endtask

    // One cycle: compare the registered outputs, drive the stimulus, compare activity, step the model.
    task automatic run_cycle();
        for (int t = 0; t < NT; t++) begin
            chk(thread_status[t*3 +: 3] == m_st[t], m_tag[t], $sformatf("status t%0d", t),
                int'(thread_status[t*3 +: 3]), int'(m_st[t]));
            chk(thread_pc[t*PC_W +: PC_W] == m_pc[t], m_tag[t], $sformatf("pc t%0d", t),
                int'(thread_pc[t*PC_W +: PC_W]), int'(m_pc[t]));
        end
        #1;
        chk(stage_active == exp_active(), "R11", "stage_active", int'(stage_active), int'(exp_active()));
        model_step();
        @(negedge clk);
    endtask

    task automatic rand_in();
        clear_in();
        for (int t = 0; t < NT; t++) begin
            thread_active[t] = ($urandom % 10) != 0;
            for (int s = 0; s < 4; s++) begin
                bit b = 1'b0, u = 1'b0;
                if (m_flag[t][s] && ($urandom % 5 == 0)) u = 1'b1;
                else if (!m_flag[t][s] && ($urandom % 8 == 0)) b = 1'b1;
                case (s)
                    0: begin dec_block[t] = b; dec_unblock[t] = u; end
                    1: begin ren_block[t] = b; ren_unblock[t] = u; end
                    2: begin exe_block[t] = b; exe_unblock[t] = u; end
                    default: begin cmt_block[t] = b; cmt_unblock[t] = u; end
                endcase
            end
            cmt_squash[t]      = ($urandom % 20) == 0;
            rob_squashing[t]   = ($urandom % 16) == 0;
            dec_squash[t]      = ($urandom % 12) == 0;
            icache_miss[t]     = ($urandom % 5) == 0;
            icache_refused[t]  = ($urandom % 8) == 0;
            icache_retry_ok[t] = ($urandom % 3) == 0;
            icache_resp[t]     = ($urandom % 3) == 0;
            fetch_select[t]    = ($urandom % 2) == 0;
            fetch_fault[t]     = ($urandom % 30) == 0;
            quiesce_hit[t]     = ($urandom % 30) == 0;
            wake[t]            = ($urandom % 6) == 0;
            cmt_redirect_pc[t*PC_W +: PC_W] = $urandom;
            dec_redirect_pc[t*PC_W +: PC_W] = $urandom;
        end
        ctx_switch = ($urandom % 30) == 0;
    endtask

    initial begin
        void'($urandom(32'h5EED_0042));
        clear_in();
        for (int t = 0; t < NT; t++) begin
            m_st[t] = S_RUN; m_pc[t] = '0; m_flag[t] = '0; m_tag[t] = "R1";
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state is compared by the first cycle below.
        run_cycle();
        // R8/R6: miss, then a decode stall arrives while waiting, then the response lands under the stall.
        clear_in(); icache_miss[0] = 1'b1; run_cycle();
        clear_in(); dec_block[0] = 1'b1; run_cycle();
        clear_in(); icache_resp[0] = 1'b1; run_cycle();
        // R2/R7: clear the flag, BLOCK returns to RUN.
        clear_in(); dec_unblock[0] = 1'b1; run_cycle();
        // R3: commit squash, flush and decode squash together.
        clear_in(); cmt_squash[1] = 1'b1; rob_squashing[1] = 1'b1; dec_squash[1] = 1'b1;
        cmt_redirect_pc[1*PC_W +: PC_W] = 32'h0000_1200; dec_redirect_pc[1*PC_W +: PC_W] = 32'h0000_BEEF;
        run_cycle();
        // R5: decode squash while already in SQUASH is ignored.
        clear_in(); dec_squash[1] = 1'b1; dec_redirect_pc[1*PC_W +: PC_W] = 32'h0000_DEAD; run_cycle();
        // R9: fault, a stall does not move TRAP, wake returns to RUN.
        clear_in(); fetch_fault[2] = 1'b1; run_cycle();
        clear_in(); ren_block[2] = 1'b1; run_cycle();
        clear_in(); wake[2] = 1'b1; run_cycle();
        clear_in(); ren_unblock[2] = 1'b1; run_cycle();
        // R10: a disabled thread ignores a commit squash.
        clear_in(); thread_active[3] = 1'b0; cmt_squash[3] = 1'b1;
        cmt_redirect_pc[3*PC_W +: PC_W] = 32'h0000_7777; run_cycle();
        // R11: no thread enabled.
        clear_in(); thread_active = '0; run_cycle();
        for (int i = 0; i < NRND; i++) begin
            rand_in();
            run_cycle();
        end
        clear_in();
        run_cycle();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule